// File: doc/BRIEF.md
# Double-Buffered Framebuffer Scan Controller

This block drives the display side of a two-bank framebuffer. A raster counter walks a 720p frame: 1650 clocks per line, 1280 of them active, and 750 lines, 720 of them active. During active positions it issues a running pixel address into the bank that is currently on screen. The 8-bit pixel index that comes back from the synchronous framebuffer memory is looked up in one of several 256-entry palettes of 24-bit colour. The colour is then emitted together with horizontal sync, vertical sync and data-enable for an external video transmitter.

The drawing engine always writes the bank reported on `drawBank`. When a frame is finished, the engine raises `swapReq`. The controller remembers the request and waits for the start of vertical blanking. At that point it exchanges the two banks and pulses `swapAck` for one cycle. A frame on screen therefore never mixes two banks. Palette contents are loaded through a write port (palette number, index and colour) at any time, and `palSel` chooses the palette used for display.

Top module: `fbscan_top`

## Requirements
- R1: After reset the raster position starts at column 0, line 0. It advances one column per clock, and a line is HACT+HFP+HSW+HBP clocks long. A frame is VACT+VFP+VSW+VBP lines, after which the position wraps to (0,0).
- R2: `vidDe` is high exactly for positions with column < HACT and line < VACT. It appears two clock edges after the position it belongs to.
- R3: `vidHsync` is high for columns HACT+HFP up to HACT+HFP+HSW-1 of every line. `vidVsync` is high for the whole of lines VACT+VFP up to VACT+VFP+VSW-1. Both are active high and share the two-edge latency of R2.
- R4: In every active position, `fbAddr` equals line*HACT+column and `fbBank` names the displayed bank, both in the same cycle. The memory returns `fbRdData` one edge later.
- R5: `vidRgb` equals palette[`palSel`][pixel], with red in bits 23:16, green in 15:8 and blue in 7:0. It appears two edges after the pixel's address and is 0 whenever `vidDe` is low. `palSel` is sampled at the edge that produces the colour.
- R6: A palette write (`palWrEn` with `palWrSel`, `palWrIdx` and `palWrData`) is accepted in any cycle, including during reset. Every lookup at a later edge sees the new value.
- R7: A `swapReq` seen in any cycle is held until vertical blanking starts. In the cycle where the position is (0,VACT), a held or present request exchanges the banks at the next edge. At that edge `swapAck` goes high for exactly one cycle and `drawBank` (always the opposite of the displayed bank) changes.
- R8: Several requests before one exchange produce a single exchange and a single acknowledge. Without a request the banks never change.
- R9: In reset all video outputs and `swapAck` are 0, bank 0 is displayed and `drawBank` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| swapReq | input | 1 | Swap request from the drawing engine |
| swapAck | output | 1 | One-cycle acknowledge when the banks exchange |
| drawBank | output | 1 | Bank the drawing engine may write |
| palSel | input | $clog2(NPAL) | Palette used for display |
| palWrEn | input | 1 | Palette write strobe |
| palWrSel | input | $clog2(NPAL) | Palette written |
| palWrIdx | input | 8 | Entry written |
| palWrData | input | 24 | Colour written, R in 23:16, G in 15:8, B in 7:0 |
| fbAddr | output | $clog2(HACT*VACT) | Scan-out pixel address |
| fbBank | output | 1 | Bank being scanned out |
| fbRdData | input | 8 | Pixel index from memory, one edge after the address |
| vidHsync | output | 1 | Horizontal sync, active high |
| vidVsync | output | 1 | Vertical sync, active high |
| vidDe | output | 1 | Data enable |
| vidRgb | output | 24 | Pixel colour |

## Verification
The address and bank outputs follow the raster position in the same cycle. The pixel index arrives one edge later, and the colour, data-enable and syncs are due two edges after the position. `swapAck` and the bank change land one edge after the cycle at (0,VACT). The bench keeps its own raster position, bank, pending request and palette copy, and queues each position's expected result. It pops each result at the edge where it is due, so palette writes and palette selection are resolved at the edge that uses them. All registered outputs are compared at every falling edge, and the address is compared there too whenever the modelled position is active.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;
  typedef struct packed {
    logic active;
    logic hsync;
    logic vsync;
  } scanStrobe_t;
endpackage

// File: rtl/fbscan_ctrl.sv
module fbscan_ctrl
  import fbscan_pkg::*;
#(
  parameter int HACT = 1280,
  parameter int HFP  = 110,
  parameter int HSW  = 40,
  parameter int HBP  = 220,
  parameter int VACT = 720,
  parameter int VFP  = 5,
  parameter int VSW  = 5,
  parameter int VBP  = 20,
  localparam int HTOT = HACT + HFP + HSW + HBP,
  localparam int VTOT = VACT + VFP + VSW + VBP,
  localparam int HW = $clog2(HTOT),
  localparam int VW = $clog2(VTOT),
  localparam int AW = $clog2(HACT * VACT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swapReq,
  output logic          swapAck,
  output logic          dispBank,
  output logic [AW-1:0] addrCnt,
  output scanStrobe_t   strobe
);
  localparam logic [HW-1:0] H_LAST = HW'(HTOT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(VTOT - 1);
  localparam logic [HW-1:0] H_ACT  = HW'(HACT);
  localparam logic [VW-1:0] V_ACT  = VW'(VACT);
  localparam logic [HW-1:0] HS_ON  = HW'(HACT + HFP);
  localparam logic [HW-1:0] HS_OFF = HW'(HACT + HFP + HSW);
  localparam logic [VW-1:0] VS_ON  = VW'(VACT + VFP);
  localparam logic [VW-1:0] VS_OFF = VW'(VACT + VFP + VSW);

  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;
  logic lineEnd, frameEnd, blankStart, reqHeld, pending;

  assign lineEnd    = (hCnt == H_LAST);
  assign frameEnd   = lineEnd && (vCnt == V_LAST);
  assign blankStart = (hCnt == '0) && (vCnt == V_ACT);
  assign reqHeld    = pending || swapReq;

  always_comb begin
    strobe.active = (hCnt < H_ACT) && (vCnt < V_ACT);
    strobe.hsync  = (hCnt >= HS_ON) && (hCnt < HS_OFF);
    strobe.vsync  = (vCnt >= VS_ON) && (vCnt < VS_OFF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
      addrCnt <= '0;
    end else begin
      hCnt <= lineEnd ? '0 : hCnt + 1'b1;
      if (lineEnd) vCnt <= frameEnd ? '0 : vCnt + 1'b1;
      if (frameEnd) addrCnt <= '0;
      else if (strobe.active) addrCnt <= addrCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dispBank <= 1'b0;
      pending  <= 1'b0;
      swapAck  <= 1'b0;
    end else if (blankStart && reqHeld) begin
      dispBank <= ~dispBank;
      pending  <= 1'b0;
      swapAck  <= 1'b1;
    end else begin
      pending  <= reqHeld;
      swapAck  <= 1'b0;
    end
  end

  a_r1_line_wrap: assert property (@(posedge clk) disable iff (rst)
    (hCnt == H_LAST) |=> (hCnt == '0));
  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    swapAck |=> !swapAck);
  a_r7_ack_in_blank: assert property (@(posedge clk) disable iff (rst)
    swapAck |-> (vCnt == V_ACT && hCnt == HW'(1)));
  a_r8_bank_needs_ack: assert property (@(posedge clk) disable iff (rst)
    (dispBank != $past(dispBank)) |-> swapAck);
endmodule

// File: rtl/fbscan_dp.sv
module fbscan_dp
  import fbscan_pkg::*;
#(
  parameter int NPAL = 4,
  localparam int SW = $clog2(NPAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  scanStrobe_t   strobe,
  input  logic [7:0]    pixIdx,
  input  logic [SW-1:0] palSel,
  input  logic          palWrEn,
  input  logic [SW-1:0] palWrSel,
  input  logic [7:0]    palWrIdx,
  input  logic [23:0]   palWrData,
  output logic          vidHsync,
  output logic          vidVsync,
  output logic          vidDe,
  output logic [23:0]   vidRgb
);
  localparam int DEPTH = NPAL * 256;

  logic [23:0] palMem [DEPTH];
  scanStrobe_t s1;

  always_ff @(posedge clk) begin
    if (palWrEn) palMem[{palWrSel, palWrIdx}] <= palWrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1       <= '0;
      vidDe    <= 1'b0;
      vidHsync <= 1'b0;
      vidVsync <= 1'b0;
      vidRgb   <= '0;
    end else begin
      s1       <= strobe;
      vidDe    <= s1.active;
      vidHsync <= s1.hsync;
      vidVsync <= s1.vsync;
      vidRgb   <= s1.active ? palMem[{palSel, pixIdx}] : '0;
    end
  end

  a_r5_rgb_blank: assert property (@(posedge clk) disable iff (rst)
    !vidDe |-> (vidRgb == '0));
endmodule

// File: rtl/fbscan_top.sv
module fbscan_top
  import fbscan_pkg::*;
#(
  parameter int HACT = 1280,
  parameter int HFP  = 110,
  parameter int HSW  = 40,
  parameter int HBP  = 220,
  parameter int VACT = 720,
  parameter int VFP  = 5,
  parameter int VSW  = 5,
  parameter int VBP  = 20,
  parameter int NPAL = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         swapReq,
  output logic                         swapAck,
  output logic                         drawBank,
  input  logic [$clog2(NPAL)-1:0]      palSel,
  input  logic                         palWrEn,
  input  logic [$clog2(NPAL)-1:0]      palWrSel,
  input  logic [7:0]                   palWrIdx,
  input  logic [23:0]                  palWrData,
  output logic [$clog2(HACT*VACT)-1:0] fbAddr,
  output logic                         fbBank,
  input  logic [7:0]                   fbRdData,
  output logic                         vidHsync,
  output logic                         vidVsync,
  output logic                         vidDe,
  output logic [23:0]                  vidRgb
);
  scanStrobe_t strobe;
  logic dispBank;

  assign fbBank   = dispBank;
  assign drawBank = ~dispBank;

  fbscan_ctrl #(
    .HACT(HACT), .HFP(HFP), .HSW(HSW), .HBP(HBP),
    .VACT(VACT), .VFP(VFP), .VSW(VSW), .VBP(VBP)
  ) u_ctrl (
    .clk(clk), .rst(rst), .swapReq(swapReq), .swapAck(swapAck),
    .dispBank(dispBank), .addrCnt(fbAddr), .strobe(strobe)
  );

  fbscan_dp #(.NPAL(NPAL)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .pixIdx(fbRdData),
    .palSel(palSel), .palWrEn(palWrEn), .palWrSel(palWrSel),
    .palWrIdx(palWrIdx), .palWrData(palWrData),
    .vidHsync(vidHsync), .vidVsync(vidVsync), .vidDe(vidDe), .vidRgb(vidRgb)
  );
endmodule

// File: tb/fbscan_top_tb.sv
module fbscan_top_tb;
  localparam int HACT = 8, HFP = 2, HSW = 2, HBP = 2;
  localparam int VACT = 4, VFP = 1, VSW = 1, VBP = 1;
  localparam int NPAL = 4;
  localparam int HTOT = HACT + HFP + HSW + HBP;
  localparam int VTOT = VACT + VFP + VSW + VBP;
  localparam int FRAME = HTOT * VTOT;
  localparam int SW = $clog2(NPAL);
  localparam int AW = $clog2(HACT * VACT);

  logic clk = 0, rst = 1;
  logic swapReq = 0, palWrEn = 0;
  logic [SW-1:0] palSel = 0, palWrSel = 0;
  logic [7:0] palWrIdx = 0, fbRdData = 0;
  logic [23:0] palWrData = 0, vidRgb;
  logic swapAck, drawBank, fbBank, vidHsync, vidVsync, vidDe;
  logic [AW-1:0] fbAddr;

  fbscan_top #(.HACT(HACT), .HFP(HFP), .HSW(HSW), .HBP(HBP),
               .VACT(VACT), .VFP(VFP), .VSW(VSW), .VBP(VBP), .NPAL(NPAL)) u_dut (
    .clk(clk), .rst(rst), .swapReq(swapReq), .swapAck(swapAck), .drawBank(drawBank),
    .palSel(palSel), .palWrEn(palWrEn), .palWrSel(palWrSel), .palWrIdx(palWrIdx),
    .palWrData(palWrData), .fbAddr(fbAddr), .fbBank(fbBank), .fbRdData(fbRdData),
    .vidHsync(vidHsync), .vidVsync(vidVsync), .vidDe(vidDe), .vidRgb(vidRgb));

  always #5 clk = ~clk;

  function automatic int pat(int bank, int addr);
    return (addr * 7 + bank * 100 + 3) % 256;
  endfunction

  // synchronous framebuffer memory model
  int memAddr = 0, memBank = 0;
  always @(negedge clk) begin memAddr = int'(fbAddr); memBank = int'(fbBank); end
  always @(posedge clk) fbRdData <= 8'(pat(memBank, memAddr));

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // reference model state
  int mPal [NPAL*256];
  int mPos = 0, mBank = 0, mPend = 0;
  int pipeQ [$];
  int eDe = 0, eHs = 0, eVs = 0, eRgb = 0, eAck = 0, ackSeen = 0;
  string rgbTag = "R5", ackTag = "R7";

  task automatic compare();
    int h, v;
    h = mPos % HTOT; v = mPos / HTOT;
    chk("R2 vidDe", int'(vidDe), eDe);
    chk("R3 vidHsync", int'(vidHsync), eHs);
    chk("R3 vidVsync", int'(vidVsync), eVs);
    chk({rgbTag, " vidRgb"}, int'(vidRgb), eRgb);
    chk({ackTag, " swapAck"}, int'(swapAck), eAck);
    chk("R7 drawBank", int'(drawBank), 1 - mBank);
    chk("R4 fbBank", int'(fbBank), mBank);
    if (h < HACT && v < VACT) chk("R1 R4 fbAddr", int'(fbAddr), v * HACT + h);
    if (swapAck) ackSeen++;
  endtask

  // one clock: compare, drive, advance model, wait for next falling edge
  task automatic tick(bit req, int sel, bit we, int ws, int wi, int wd);
    int h, v, e, trig, rq;
    compare();
    swapReq = req; palSel = SW'(sel); palWrEn = we;
    palWrSel = SW'(ws); palWrIdx = 8'(wi); palWrData = 24'(wd);
    if (pipeQ.size() > 0) begin
      e = pipeQ.pop_front();
      eDe = (e >> 10) & 1; eHs = (e >> 9) & 1; eVs = (e >> 8) & 1;
      eRgb = eDe ? mPal[sel * 256 + (e & 255)] : 0;
    end else begin
      eDe = 0; eHs = 0; eVs = 0; eRgb = 0;
    end
    h = mPos % HTOT; v = mPos / HTOT;
    e = pat(mBank, v * HACT + h);
    if (h < HACT && v < VACT) e |= 1 << 10;
    if (h >= HACT + HFP && h < HACT + HFP + HSW) e |= 1 << 9;
    if (v >= VACT + VFP && v < VACT + VFP + VSW) e |= 1 << 8;
    pipeQ.push_back(e);
    trig = (h == 0 && v == VACT);
    rq = mPend | int'(req);
    eAck = trig & rq;
    if (eAck != 0) mBank = 1 - mBank;
    mPend = rq & (1 - trig);
    if (we) mPal[ws * 256 + wi] = wd;
    mPos = (mPos + 1) % FRAME;
    cycles++;
    @(negedge clk);
  endtask

  task automatic run(int n, int sel);
    for (int i = 0; i < n; i++) tick(0, sel, 0, 0, 0, 0);
  endtask

  function automatic int palInit(int s, int i);
    return (((s * 17) ^ i) << 16) | (i << 8) | (255 - i);
  endfunction

  initial begin
    @(negedge clk);
    // R6: load every palette while reset is held
    for (int s = 0; s < NPAL; s++)
      for (int i = 0; i < 256; i++) begin
        palWrEn = 1; palWrSel = SW'(s); palWrIdx = 8'(i); palWrData = 24'(palInit(s, i));
        mPal[s * 256 + i] = palInit(s, i);
        @(negedge clk);
      end
    palWrEn = 0;
    @(negedge clk);
    // R9: reset state
    chk("R9 vidDe", int'(vidDe), 0);
    chk("R9 vidRgb", int'(vidRgb), 0);
    chk("R9 syncs", int'({vidHsync, vidVsync}), 0);
    chk("R9 swapAck", int'(swapAck), 0);
    chk("R9 fbBank", int'(fbBank), 0);
    chk("R9 drawBank", int'(drawBank), 1);
    rst = 0;
    // R1 R2 R3 R5 R8: two plain frames, no request means no swap
    ackTag = "R8";
    run(2 * FRAME, 0);
    rgbTag = "R5";
    run(FRAME, 1);
    // R7: pulse mid-frame
    ackTag = "R7";
    while (mPos != 20) tick(0, 1, 0, 0, 0, 0);
    tick(1, 1, 0, 0, 0, 0);
    run(2 * FRAME, 1);
    // R7: request exactly in the blank-start cycle
    while (mPos != VACT * HTOT) tick(0, 2, 0, 0, 0, 0);
    tick(1, 2, 0, 0, 0, 0);
    run(FRAME, 2);
    // R8: two requests in one frame merge into one swap
    ackTag = "R8";
    while (mPos != 5) tick(0, 2, 0, 0, 0, 0);
    ackSeen = 0;
    tick(1, 2, 0, 0, 0, 0);
    run(10, 2);
    tick(1, 2, 0, 0, 0, 0);
    run(FRAME, 2);
    chk("R8 single ack for merged requests", ackSeen, 1);
    // R6: rewrite palette entries while they are being displayed
    rgbTag = "R6";
    for (int k = 0; k < 3 * FRAME; k++)
      tick(0, 3, 1, 3, (k * 7 + 3) % 256, (k * 2654435) & 24'hffffff);
    run(FRAME, 3);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule